// File: doc/BRIEF.md
# Directed Rounding and Overflow-Direction Unit

This combinational unit finishes the rounding step of a floating-point result. It takes an unsigned mantissa whose two lowest bits hold the guard and round positions, together with a separate sticky bit, the sign of the result and a 2-bit rounding-mode code. The unit drops the guard and round bits. It then decides, for the chosen IEEE direction, whether to add one to what remains. It returns the rounded mantissa, which is one bit wider so that a carry-out can be seen, plus a flag that reports the increment and a flag that reports an inexact result.

A separate output tells the caller what an overflowing result of the given sign should saturate to: infinity, or the largest finite magnitude. Renormalisation after a carry-out is left to the caller. The caller reads the round-up flag and the top output bit, and adjusts the exponent itself.

Mode encoding on `round_mode`: 0 = to nearest (ties to even), 1 = toward zero, 2 = toward plus infinity, 3 = toward minus infinity.

Top module: `rnd_dir_unit`

## Requirements
- R1: `mant_rnd` equals `mant_in` shifted right by two, plus one when `round_up` is high, held in MANT_W-1 bits. Bit 1 of `mant_in` is guard and bit 0 is round.
- R2: When guard, round and `sticky_in` are all zero, `round_up` and `inexact` are both low and `mant_rnd` is `mant_in` shifted right by two.
- R3: `inexact` is high whenever guard, round or `sticky_in` is set, in every mode.
- R4: In mode 0, `round_up` is high only when guard is set and at least one of round, sticky or the LSB of the shifted mantissa (`mant_in` bit 2) is set.
- R5: In mode 0, a tie (guard set, round and sticky clear) rounds to even: it increments only when `mant_in` bit 2 is 1.
- R6: In mode 1, `round_up` is never high.
- R7: In mode 2, `round_up` is high exactly when the result is inexact and `sign_in` is 0.
- R8: In mode 3, `round_up` is high exactly when the result is inexact and `sign_in` is 1.
- R9: The increment carries across the full width. An all-ones shifted mantissa that rounds up gives 1 in the top bit of `mant_rnd` and zeros below it, with no correction applied.
- R10: `ovf_to_inf` is 1 in mode 0 and 0 in mode 1. In mode 2 it equals the inverse of `sign_in`, and in mode 3 it equals `sign_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mant_in | input | MANT_W | Mantissa; bit 1 guard, bit 0 round |
| sticky_in | input | 1 | OR of all bits already shifted out below round |
| sign_in | input | 1 | Sign of the value, 1 = negative |
| round_mode | input | 2 | Rounding direction code |
| mant_rnd | output | MANT_W-1 | Rounded mantissa including carry-out bit |
| round_up | output | 1 | An increment was applied |
| inexact | output | 1 | Discarded bits were not all zero |
| ovf_to_inf | output | 1 | Overflow goes to infinity (1) or to the largest finite value (0) |

## Verification
Immediate assertions check four things at every input change. An increment never happens on an exact value. Toward-zero never increments. The directed modes never increment against the sign. A carry-out only appears when the shifted mantissa is all ones. Whether the nearest mode breaks ties toward even, and whether the sum and the overflow choice carry the exact values required, can only be shown by the bench's scenarios. Those compare against an independent reference over tie patterns, all-ones carry cases, sign and mode sweeps, and random vectors.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RDIR_NEAR = 2'd0,
    RDIR_ZERO = 2'd1,
    RDIR_POS  = 2'd2,
    RDIR_NEG  = 2'd3
  } rdir_e;

  // Increment decision for one direction, given the lost bits and sign.
  function automatic logic step_up(rdir_e dir, logic grd, logic rnd,
                                   logic stk, logic lsb, logic neg);
    logic lost;
    lost = grd | rnd | stk;
    case (dir)
      RDIR_NEAR: step_up = grd & (rnd | stk | lsb);
      RDIR_ZERO: step_up = 1'b0;
      RDIR_POS:  step_up = lost & ~neg;
      RDIR_NEG:  step_up = lost & neg;
      default:   step_up = grd & (rnd | stk | lsb);
    endcase
  endfunction

  // Overflow target: 1 = infinity, 0 = largest finite magnitude.
  function automatic logic sat_inf(rdir_e dir, logic neg);
    case (dir)
      RDIR_NEAR: sat_inf = 1'b1;
      RDIR_ZERO: sat_inf = 1'b0;
      RDIR_POS:  sat_inf = ~neg;
      RDIR_NEG:  sat_inf = neg;
      default:   sat_inf = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/grs_split.sv
module grs_split #(
  parameter int MANT_W = 26,
  localparam int KEEP_W = MANT_W - 2
) (
  input  logic [MANT_W-1:0] mant,
  input  logic              stk,
  output logic [KEEP_W-1:0] kept,
  output logic              grd,
  output logic              rnd,
  output logic              lsb,
  output logic              lost
);
  assign kept = mant[MANT_W-1:2];
  assign grd  = mant[1];
  assign rnd  = mant[0];
  assign lsb  = mant[2];
  assign lost = mant[1] | mant[0] | stk;
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       neg,
  input  logic       grd,
  input  logic       rnd,
  input  logic       stk,
  input  logic       lsb,
  input  logic       lost,
  output logic       inc
);
  rdir_e dir;
  assign dir = rdir_e'(mode);
  assign inc = step_up(dir, grd, rnd, stk, lsb, neg);

  always_comb begin
    if (!lost) AST_EXACT_NO_INC: assert (!inc);                        // R2
    if (dir == RDIR_ZERO) AST_RZ_NO_INC: assert (!inc);               // R6
    if (dir == RDIR_NEAR && !grd) AST_RN_NEED_GUARD: assert (!inc);    // R4
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int KEEP_W = 24,
  localparam int SUM_W = KEEP_W + 1
) (
  input  logic [KEEP_W-1:0] kept,
  input  logic              inc,
  output logic [SUM_W-1:0]  sum
);
  logic [KEEP_W:0] carry;
  assign carry[0] = inc;

  for (genvar i = 0; i < KEEP_W; i++) begin : g_ripple
    assign sum[i]     = kept[i] ^ carry[i];
    assign carry[i+1] = kept[i] & carry[i];
  end
  assign sum[KEEP_W] = carry[KEEP_W];

  always_comb begin
    if (sum[KEEP_W]) AST_CARRY_ALL_ONES: assert (inc && (&kept));       // R9
    if (!inc) AST_NO_INC_PASS: assert (sum == {1'b0, kept});           // R1
  end
endmodule

// File: rtl/ovf_dir.sv
module ovf_dir
  import rnd_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       neg,
  output logic       to_inf
);
  assign to_inf = sat_inf(rdir_e'(mode), neg);
endmodule

// File: rtl/rnd_dir_unit.sv
module rnd_dir_unit #(
  parameter int MANT_W = 26,
  localparam int KEEP_W = MANT_W - 2,
  localparam int OUT_W  = MANT_W - 1
) (
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        round_mode,
  output logic [OUT_W-1:0]  mant_rnd,
  output logic              round_up,
  output logic              inexact,
  output logic              ovf_to_inf
);
  logic [KEEP_W-1:0] kept_w;
  logic guard_w, rbit_w, lsb_w, lost_w, inc_w;

  grs_split #(.MANT_W(MANT_W)) u_split (
    .mant(mant_in), .stk(sticky_in), .kept(kept_w),
    .grd(guard_w), .rnd(rbit_w), .lsb(lsb_w), .lost(lost_w)
  );

  rnd_decide u_decide (
    .mode(round_mode), .neg(sign_in), .grd(guard_w), .rnd(rbit_w),
    .stk(sticky_in), .lsb(lsb_w), .lost(lost_w), .inc(inc_w)
  );

  rnd_incr #(.KEEP_W(KEEP_W)) u_incr (
    .kept(kept_w), .inc(inc_w), .sum(mant_rnd)
  );

  ovf_dir u_ovf (
    .mode(round_mode), .neg(sign_in), .to_inf(ovf_to_inf)
  );

  assign round_up = inc_w;
  assign inexact  = lost_w;

  always_comb begin
    if (round_up) AST_UP_IMPLIES_INEXACT: assert (inexact);                       // R3
    if (round_mode == 2'd2 && sign_in) AST_RP_NEG_NO_UP: assert (!round_up);     // R7
    if (round_mode == 2'd3 && !sign_in) AST_RM_POS_NO_UP: assert (!round_up);    // R8
    if (round_mode == 2'd1) AST_RZ_FINITE: assert (!ovf_to_inf);                 // R10
  end
endmodule

// File: tb/sim_rnd_dir_unit.sv
module sim_rnd_dir_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 26;
  localparam int OW = MW - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [MW-1:0] mant_in;
  logic sticky_in, sign_in;
  logic [1:0] round_mode;
  logic [OW-1:0] mant_rnd;
  logic round_up, inexact, ovf_to_inf;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  rnd_dir_unit #(.MANT_W(MW)) u0 (
    .mant_in(mant_in), .sticky_in(sticky_in), .sign_in(sign_in),
    .round_mode(round_mode), .mant_rnd(mant_rnd), .round_up(round_up),
    .inexact(inexact), .ovf_to_inf(ovf_to_inf)
  );

  // Reference: judge the discarded fraction as a 3-bit value g,r,s.
  function automatic logic ref_up(logic [MW-1:0] m, logic s, logic neg, logic [1:0] md);
    int frac;
    frac = {m[1:0], s};
    case (md)
      2'd0: ref_up = (frac > 4) || (frac == 4 && m[2]);
      2'd1: ref_up = 1'b0;
      2'd2: ref_up = (frac != 0) && !neg;
      default: ref_up = (frac != 0) && neg;
    endcase
  endfunction

  task automatic check(string tag, logic [MW-1:0] m, logic s, logic neg, logic [1:0] md);
    logic exp_up, exp_nx, exp_inf;
    logic [OW-1:0] exp_m;
    mant_in = m; sticky_in = s; sign_in = neg; round_mode = md;
    @(negedge clk);
    exp_up  = ref_up(m, s, neg, md);
    exp_nx  = (m[1:0] != 2'b00) || s;
    exp_m   = OW'({1'b0, m[MW-1:2]}) + OW'(exp_up);
    exp_inf = (md == 2'd0) ? 1'b1 : (md == 2'd1) ? 1'b0 : (md == 2'd2) ? !neg : neg;
    n_vec++;
    if (mant_rnd !== exp_m || round_up !== exp_up || inexact !== exp_nx || ovf_to_inf !== exp_inf) begin
      n_bad++;
      $display("FAIL %s: m=%h s=%0d sg=%0d md=%0d got %h/%0d/%0d/%0d exp %h/%0d/%0d/%0d",
               tag, m, s, neg, md, mant_rnd, round_up, inexact, ovf_to_inf,
               exp_m, exp_up, exp_nx, exp_inf);
    end
  endtask

  task automatic t_zero_state();  // R1 R2: all-zero inputs
    check("R1_zero", '0, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_exact();  // R2: nothing lost, every mode and sign
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        check("R2_exact", MW'(26'h2abcd4), 1'b0, sg[0], md[1:0]);
  endtask

  task automatic t_inexact();  // R3: each lost bit alone sets inexact
    for (int md = 0; md < 4; md++) begin
      check("R3_guard", MW'(26'h1000002), 1'b0, 1'b0, md[1:0]);
      check("R3_round", MW'(26'h1000001), 1'b0, 1'b1, md[1:0]);
      check("R3_sticky", MW'(26'h1000000), 1'b1, 1'b0, md[1:0]);
    end
  endtask

  task automatic t_nearest();  // R4 R5: ties and above/below half
    check("R4_below", MW'(26'h0000105), 1'b1, 1'b0, 2'd0);
    check("R4_above_r", MW'(26'h0000103), 1'b0, 1'b0, 2'd0);
    check("R4_above_s", MW'(26'h0000102), 1'b1, 1'b1, 2'd0);
    check("R5_tie_even", MW'(26'h0000102), 1'b0, 1'b0, 2'd0);
    check("R5_tie_odd", MW'(26'h0000106), 1'b0, 1'b1, 2'd0);
  endtask

  task automatic t_zero_dir();  // R6
    check("R6_max_lost", MW'(26'h0000107), 1'b1, 1'b0, 2'd1);
    check("R6_neg", MW'(26'h3ffffff), 1'b1, 1'b1, 2'd1);
  endtask

  task automatic t_directed();  // R7 R8
    check("R7_pos_up", MW'(26'h0000101), 1'b0, 1'b0, 2'd2);
    check("R7_neg_down", MW'(26'h0000101), 1'b0, 1'b1, 2'd2);
    check("R8_neg_up", MW'(26'h0000100), 1'b1, 1'b1, 2'd3);
    check("R8_pos_down", MW'(26'h0000100), 1'b1, 1'b0, 2'd3);
  endtask

  task automatic t_carry();  // R9: all-ones kept part rounds to 2.0
    check("R9_rn", MW'(26'h3ffffff), 1'b0, 1'b0, 2'd0);
    check("R9_rp", MW'(26'h3fffffd), 1'b0, 1'b0, 2'd2);
    check("R9_rm", MW'(26'h3fffffc), 1'b1, 1'b1, 2'd3);
    check("R9_exact", MW'(26'h3fffffc), 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_overflow();  // R10
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        check("R10_ovf", MW'(26'h1234567), 1'b0, sg[0], md[1:0]);
  endtask

  task automatic t_random();  // R1 R4: random vectors
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      check("R1_rand", MW'($urandom), rv[0], rv[1], rv[3:2]);
    end
  endtask

  initial begin
    mant_in = '0; sticky_in = 1'b0; sign_in = 1'b0; round_mode = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_zero_state();
    t_exact();
    t_inexact();
    t_nearest();
    t_zero_dir();
    t_directed();
    t_carry();
    t_overflow();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: R1 run hung, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule